// File: doc/BRIEF.md
# VLAN Membership Resolution Table

This block keeps a small associative table of VLAN entries for a multi-port Ethernet switch. Each entry holds a 12-bit VLAN ID, a membership mask with one bit per port, and a tagged mask with one bit per port. Software-style writes through a single write port add, update or free entries by index. The table starts empty after reset.

A lookup request carries an ingress port and a VLAN ID. All entries are compared in parallel. One clock later the block returns whether a valid entry matched, the egress membership mask and the tagged mask of that entry. It also returns a forward/drop decision and a flood mask. The decision uses two per-port controls. The discard enable drops frames whose ingress port is not a member of the VLAN. The verify enable restricts flooding to the VLAN's members instead of a default flood mask.

The flood mask is intended for frames whose destination address missed a forwarding database keyed without the VLAN ID. The default VLAN value of a port has no effect here. Membership comes only from what has been written into the table.

Top module: `vlan_res_top`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses until an entry is written, and all lookup outputs are 0.
- R2: `lk_valid_o` is 1 exactly in the cycle after a cycle with `lk_req_i` high and 0 otherwise. All other lookup outputs for that request are presented in that same cycle.
- R3: A write with `wr_en_i=1` and `wr_valid_i=1` stores `wr_vid_i`, `wr_member_i` and `wr_tagged_i` at entry `wr_idx_i`. Writing the same index again replaces its contents. A later lookup of that VLAN ID sets `lk_hit_o=1` and returns both masks.
- R4: A write with `wr_valid_i=0` frees entry `wr_idx_i`. Lookups of its former VLAN ID then miss, unless another valid entry holds the same ID.
- R5: When several valid entries hold the requested VLAN ID, the entry with the lowest index supplies the masks.
- R6: On a miss, `lk_member_o` and `lk_tagged_o` are 0.
- R7: If the ingress port's bit of `discard_en_i` is 1, the frame is dropped (`lk_fwd_o=0`, `lk_flood_o=0`) when the lookup misses or the port's bit in the matched membership mask is 0.
- R8: If the ingress port's bit of `discard_en_i` is 0, `lk_fwd_o=1` whatever the table contents are.
- R9: For a forwarded frame, `lk_flood_o` equals the matched membership mask when the lookup hits and the ingress port's bit of `verify_en_i` is 1. Otherwise it equals `dflt_flood_i`.
- R10: A lookup issued in the same cycle as a write sees the table contents from before that write. The write is visible to requests from the next cycle on.
- R11: A match needs all 12 VLAN ID bits to be equal. An ID that differs in any single bit does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | $clog2(N_ENTRIES) | Entry index to write |
| wr_valid_i | input | 1 | 1 stores the entry, 0 frees it |
| wr_vid_i | input | 12 | VLAN ID to store |
| wr_member_i | input | N_PORTS | Membership mask to store |
| wr_tagged_i | input | N_PORTS | Tagged mask to store |
| discard_en_i | input | N_PORTS | Per-port drop of non-member traffic |
| verify_en_i | input | N_PORTS | Per-port flooding restricted to VLAN members |
| dflt_flood_i | input | N_PORTS | Default flood mask |
| lk_req_i | input | 1 | Lookup request |
| lk_port_i | input | $clog2(N_PORTS) | Ingress port of the lookup |
| lk_vid_i | input | 12 | VLAN ID of the lookup |
| lk_valid_o | output | 1 | Lookup result strobe |
| lk_hit_o | output | 1 | A valid entry matched |
| lk_member_o | output | N_PORTS | Membership mask of the match |
| lk_tagged_o | output | N_PORTS | Tagged mask of the match |
| lk_fwd_o | output | 1 | 1 forward, 0 drop |
| lk_flood_o | output | N_PORTS | Flood mask for the frame |

## Verification
Every lookup result is due one rising edge after its request. The bench raises the request at a falling edge and reads all outputs at the next falling edge, where the strobe must be high. It checks the strobe low again one cycle later. Writes land on the edge that ends their cycle, so the bench compares against a model updated only after that edge. A request issued together with a write is expected to see the old contents, and the next request the new ones.

// File: rtl/vlan_res_pkg.sv
package vlan_res_pkg;
  localparam int unsigned VID_W = 12;
  typedef logic [VID_W-1:0] vid_t;
endpackage

// File: rtl/vlan_res_store.sv
module vlan_res_store
  import vlan_res_pkg::*;
#(
  parameter int unsigned N_PORTS   = 4,
  parameter int unsigned N_ENTRIES = 32,
  localparam int unsigned IW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [IW-1:0]                     wr_idx_i,
  input  logic                              wr_valid_i,
  input  vid_t                              wr_vid_i,
  input  logic [N_PORTS-1:0]                wr_member_i,
  input  logic [N_PORTS-1:0]                wr_tagged_i,
  output logic [N_ENTRIES-1:0]              ent_valid_o,
  output logic [N_ENTRIES-1:0][VID_W-1:0]   ent_vid_o,
  output logic [N_ENTRIES-1:0][N_PORTS-1:0] ent_member_o,
  output logic [N_ENTRIES-1:0][N_PORTS-1:0] ent_tagged_o
);
  logic [N_ENTRIES-1:0]              valid_q;
  logic [N_ENTRIES-1:0][VID_W-1:0]   vid_q;
  logic [N_ENTRIES-1:0][N_PORTS-1:0] mem_q;
  logic [N_ENTRIES-1:0][N_PORTS-1:0] tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      vid_q   <= '0;
      mem_q   <= '0;
      tag_q   <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < int'(N_ENTRIES); i++) begin
        if (wr_idx_i == IW'(i)) begin
          valid_q[i] <= wr_valid_i;
          // freed entries are zeroed so stale masks never leak
          vid_q[i]   <= wr_valid_i ? wr_vid_i    : '0;
          mem_q[i]   <= wr_valid_i ? wr_member_i : '0;
          tag_q[i]   <= wr_valid_i ? wr_tagged_i : '0;
        end
      end
    end
  end

  assign ent_valid_o  = valid_q;
  assign ent_vid_o    = vid_q;
  assign ent_member_o = mem_q;
  assign ent_tagged_o = tag_q;
endmodule

// File: rtl/vlan_res_match.sv
module vlan_res_match
  import vlan_res_pkg::*;
#(
  parameter int unsigned N_PORTS   = 4,
  parameter int unsigned N_ENTRIES = 32
) (
  input  logic [N_ENTRIES-1:0]              ent_valid_i,
  input  logic [N_ENTRIES-1:0][VID_W-1:0]   ent_vid_i,
  input  logic [N_ENTRIES-1:0][N_PORTS-1:0] ent_member_i,
  input  logic [N_ENTRIES-1:0][N_PORTS-1:0] ent_tagged_i,
  input  vid_t                              vid_i,
  output logic                              hit_o,
  output logic [N_PORTS-1:0]                member_o,
  output logic [N_PORTS-1:0]                tagged_o
);
  logic [N_ENTRIES-1:0] cmp;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign cmp[g] = ent_valid_i[g] && (ent_vid_i[g] == vid_i);
  end

  // lowest matching index wins
  always_comb begin
    hit_o    = 1'b0;
    member_o = '0;
    tagged_o = '0;
    for (int i = 0; i < int'(N_ENTRIES); i++) begin
      if (cmp[i] && !hit_o) begin
        hit_o    = 1'b1;
        member_o = ent_member_i[i];
        tagged_o = ent_tagged_i[i];
      end
    end
  end
endmodule

// File: rtl/vlan_res_decide.sv
module vlan_res_decide #(
  parameter int unsigned N_PORTS = 4,
  localparam int unsigned PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic               hit_i,
  input  logic [N_PORTS-1:0] member_i,
  input  logic [PW-1:0]      port_i,
  input  logic [N_PORTS-1:0] discard_en_i,
  input  logic [N_PORTS-1:0] verify_en_i,
  input  logic [N_PORTS-1:0] dflt_flood_i,
  output logic               fwd_o,
  output logic [N_PORTS-1:0] flood_o
);
  logic in_range, is_member, disc, ver, drop;

  always_comb begin
    in_range  = (32'(port_i) < N_PORTS);
    is_member = in_range && member_i[port_i];
    disc      = in_range && discard_en_i[port_i];
    ver       = in_range && verify_en_i[port_i];
    drop      = disc && !(hit_i && is_member);
    fwd_o     = !drop;
    if (drop)              flood_o = '0;
    else if (hit_i && ver) flood_o = member_i;
    else                   flood_o = dflt_flood_i;
  end
endmodule

// File: rtl/vlan_res_top.sv
module vlan_res_top
  import vlan_res_pkg::*;
#(
  parameter int unsigned N_PORTS   = 4,
  parameter int unsigned N_ENTRIES = 32,
  localparam int unsigned IW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int unsigned PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IW-1:0]      wr_idx_i,
  input  logic               wr_valid_i,
  input  logic [11:0]        wr_vid_i,
  input  logic [N_PORTS-1:0] wr_member_i,
  input  logic [N_PORTS-1:0] wr_tagged_i,
  input  logic [N_PORTS-1:0] discard_en_i,
  input  logic [N_PORTS-1:0] verify_en_i,
  input  logic [N_PORTS-1:0] dflt_flood_i,
  input  logic               lk_req_i,
  input  logic [PW-1:0]      lk_port_i,
  input  logic [11:0]        lk_vid_i,
  output logic               lk_valid_o,
  output logic               lk_hit_o,
  output logic [N_PORTS-1:0] lk_member_o,
  output logic [N_PORTS-1:0] lk_tagged_o,
  output logic               lk_fwd_o,
  output logic [N_PORTS-1:0] lk_flood_o
);
  logic [N_ENTRIES-1:0]              ent_valid;
  logic [N_ENTRIES-1:0][VID_W-1:0]   ent_vid;
  logic [N_ENTRIES-1:0][N_PORTS-1:0] ent_member;
  logic [N_ENTRIES-1:0][N_PORTS-1:0] ent_tagged;

  logic               m_hit, d_fwd;
  logic [N_PORTS-1:0] m_member, m_tagged, d_flood;

  vlan_res_store #(.N_PORTS(N_PORTS), .N_ENTRIES(N_ENTRIES)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_idx_i     (wr_idx_i),
    .wr_valid_i   (wr_valid_i),
    .wr_vid_i     (wr_vid_i),
    .wr_member_i  (wr_member_i),
    .wr_tagged_i  (wr_tagged_i),
    .ent_valid_o  (ent_valid),
    .ent_vid_o    (ent_vid),
    .ent_member_o (ent_member),
    .ent_tagged_o (ent_tagged)
  );

  vlan_res_match #(.N_PORTS(N_PORTS), .N_ENTRIES(N_ENTRIES)) u_match (
    .ent_valid_i  (ent_valid),
    .ent_vid_i    (ent_vid),
    .ent_member_i (ent_member),
    .ent_tagged_i (ent_tagged),
    .vid_i        (lk_vid_i),
    .hit_o        (m_hit),
    .member_o     (m_member),
    .tagged_o     (m_tagged)
  );

  vlan_res_decide #(.N_PORTS(N_PORTS)) u_decide (
    .hit_i        (m_hit),
    .member_i     (m_member),
    .port_i       (lk_port_i),
    .discard_en_i (discard_en_i),
    .verify_en_i  (verify_en_i),
    .dflt_flood_i (dflt_flood_i),
    .fwd_o        (d_fwd),
    .flood_o      (d_flood)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_valid_o  <= 1'b0;
      lk_hit_o    <= 1'b0;
      lk_member_o <= '0;
      lk_tagged_o <= '0;
      lk_fwd_o    <= 1'b0;
      lk_flood_o  <= '0;
    end else begin
      lk_valid_o <= lk_req_i;
      if (lk_req_i) begin
        lk_hit_o    <= m_hit;
        lk_member_o <= m_member;
        lk_tagged_o <= m_tagged;
        lk_fwd_o    <= d_fwd;
        lk_flood_o  <= d_flood;
      end
    end
  end
endmodule

// File: rtl/vlan_res_checker.sv
module vlan_res_checker #(
  parameter int unsigned N_PORTS = 4,
  localparam int unsigned PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_PORTS-1:0] discard_en_i,
  input logic [N_PORTS-1:0] verify_en_i,
  input logic [N_PORTS-1:0] dflt_flood_i,
  input logic               lk_req_i,
  input logic [PW-1:0]      lk_port_i,
  input logic               lk_valid_o,
  input logic               lk_hit_o,
  input logic [N_PORTS-1:0] lk_member_o,
  input logic [N_PORTS-1:0] lk_tagged_o,
  input logic               lk_fwd_o,
  input logic [N_PORTS-1:0] lk_flood_o
);
  logic [PW-1:0]      port_q;
  logic               disc_q, ver_q;
  logic [N_PORTS-1:0] dflt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_q <= '0;
      disc_q <= 1'b0;
      ver_q  <= 1'b0;
      dflt_q <= '0;
    end else if (lk_req_i) begin
      port_q <= lk_port_i;
      disc_q <= discard_en_i[lk_port_i];
      ver_q  <= verify_en_i[lk_port_i];
      dflt_q <= dflt_flood_i;
    end
  end

  logic member_bit;
  assign member_bit = ((lk_member_o >> port_q) & N_PORTS'(1)) != '0;

  AST_VALID_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_i |=> lk_valid_o); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_req_i |=> !lk_valid_o); // R2
  AST_MISS_EMPTY_MASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_o && !lk_hit_o) |-> (lk_member_o == '0 && lk_tagged_o == '0)); // R6
  AST_DISCARD_NONMEMBER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_o && disc_q && lk_fwd_o) |-> (lk_hit_o && member_bit)); // R7
  AST_DROP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_o && !lk_fwd_o) |-> (lk_flood_o == '0)); // R7
  AST_NO_DISCARD_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_o && !disc_q) |-> lk_fwd_o); // R8
  AST_VERIFY_FLOOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_o && lk_fwd_o && lk_hit_o && ver_q) |-> (lk_flood_o == lk_member_o)); // R9
  AST_DEFAULT_FLOOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_o && lk_fwd_o && !(lk_hit_o && ver_q)) |-> (lk_flood_o == dflt_q)); // R9
endmodule

bind vlan_res_top vlan_res_checker #(.N_PORTS(N_PORTS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .discard_en_i (discard_en_i),
  .verify_en_i  (verify_en_i),
  .dflt_flood_i (dflt_flood_i),
  .lk_req_i     (lk_req_i),
  .lk_port_i    (lk_port_i),
  .lk_valid_o   (lk_valid_o),
  .lk_hit_o     (lk_hit_o),
  .lk_member_o  (lk_member_o),
  .lk_tagged_o  (lk_tagged_o),
  .lk_fwd_o     (lk_fwd_o),
  .lk_flood_o   (lk_flood_o)
);

// File: tb/vlan_res_top_bench.sv
module vlan_res_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NE = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          wr_en = 0, wr_valid = 0;
  logic [4:0]    wr_idx = '0;
  logic [11:0]   wr_vid = '0;
  logic [NP-1:0] wr_mem = '0, wr_tag = '0;
  logic [NP-1:0] disc = '0, ver = '0, dflt = '0;
  logic          req = 0;
  logic [1:0]    port = '0;
  logic [11:0]   vid = '0;
  logic          o_valid, o_hit, o_fwd;
  logic [NP-1:0] o_mem, o_tag, o_flood;

  vlan_res_top u_vlan_res_top (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_valid_i(wr_valid), .wr_vid_i(wr_vid),
    .wr_member_i(wr_mem), .wr_tagged_i(wr_tag),
    .discard_en_i(disc), .verify_en_i(ver), .dflt_flood_i(dflt),
    .lk_req_i(req), .lk_port_i(port), .lk_vid_i(vid),
    .lk_valid_o(o_valid), .lk_hit_o(o_hit), .lk_member_o(o_mem), .lk_tagged_o(o_tag),
    .lk_fwd_o(o_fwd), .lk_flood_o(o_flood)
  );

  int total = 0, bad = 0;

  // table model
  logic          m_v   [NE];
  logic [11:0]   m_vid [NE];
  logic [NP-1:0] m_mem [NE];
  logic [NP-1:0] m_tag [NE];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] expect_out(input logic [1:0] p, input logic [11:0] v,
      input logic [NP-1:0] d, input logic [NP-1:0] vr, input logic [NP-1:0] df);
    logic h = 0, f, drop;
    logic [NP-1:0] mm = '0, tt = '0, fl;
    for (int i = 0; i < NE; i++)
      if (!h && m_v[i] && m_vid[i] == v) begin h = 1; mm = m_mem[i]; tt = m_tag[i]; end
    drop = d[p] && !(h && mm[p]);
    f = !drop;
    fl = drop ? '0 : (h && vr[p]) ? mm : df;
    return {17'd0, 1'b1, h, f, mm, tt, fl};
  endfunction

  task automatic model_write(input int idx, input logic v, input logic [11:0] id,
      input logic [NP-1:0] mm, input logic [NP-1:0] tt);
    m_v[idx] = v; m_vid[idx] = v ? id : '0;
    m_mem[idx] = v ? mm : '0; m_tag[idx] = v ? tt : '0;
  endtask

  task automatic do_write(input int idx, input logic v, input logic [11:0] id,
      input logic [NP-1:0] mm, input logic [NP-1:0] tt);
    @(negedge clk);
    wr_en = 1; wr_idx = 5'(idx); wr_valid = v; wr_vid = id; wr_mem = mm; wr_tag = tt;
    @(negedge clk);
    wr_en = 0;
    model_write(idx, v, id, mm, tt);
  endtask

  // optional write in the same cycle as the request
  task automatic do_lookup(input string tag, input int p, input logic [11:0] v,
      input logic [NP-1:0] d, input logic [NP-1:0] vr, input logic [NP-1:0] df,
      input logic with_wr, input int widx, input logic [11:0] wid);
    logic [31:0] exp;
    @(negedge clk);
    req = 1; port = 2'(p); vid = v; disc = d; ver = vr; dflt = df;
    if (with_wr) begin
      wr_en = 1; wr_idx = 5'(widx); wr_valid = 1; wr_vid = wid; wr_mem = 4'hF; wr_tag = 4'h1;
    end
    exp = expect_out(2'(p), v, d, vr, df);
    @(negedge clk);
    req = 0; wr_en = 0;
    if (with_wr) model_write(widx, 1, wid, 4'hF, 4'h1);
    check(tag, {17'd0, o_valid, o_hit, o_fwd, o_mem, o_tag, o_flood}, exp);
  endtask

  function automatic logic [11:0] ent_vid(input int i);
    return 12'(12'h100 + i * 37);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NE; i++) model_write(i, 0, '0, '0, '0);
    #(CLK_PERIOD * 3);
    @(negedge clk);
    check("R1 reset outputs", {26'd0, o_valid, o_hit, o_fwd, o_mem, o_tag, o_flood}, '0);
    rst_n = 1;
    // R1 / R6: empty table after reset
    do_lookup("R1 empty miss vid0", 0, 12'h000, 4'h0, 4'h0, 4'h5, 0, 0, '0);
    do_lookup("R6 empty miss", 2, ent_vid(3), 4'h0, 4'hF, 4'hA, 0, 0, '0);
    do_lookup("R7 empty miss discard", 1, ent_vid(0), 4'hF, 4'h0, 4'hF, 0, 0, '0);
    @(negedge clk);
    check("R2 valid low when idle", {31'd0, o_valid}, 32'd0);

    // R3: fill the table
    for (int i = 0; i < NE; i++)
      do_write(i, 1, ent_vid(i), 4'((i * 5 + 3) & 15), 4'((i * 3) & ((i * 5 + 3) & 15)));
    // R3 R7 R8 R9: sweep entries, ports and control combinations
    for (int i = 0; i < NE; i++)
      for (int p = 0; p < NP; p++)
        for (int c = 0; c < 4; c++)
          do_lookup("R3 R7 R8 R9 sweep", p, ent_vid(i),
                    c[0] ? 4'hF : 4'h0, c[1] ? 4'hF : 4'h0, 4'((i + p + c) & 15), 0, 0, '0);
    // R6 R7 R8: misses with mixed per-port controls
    for (int p = 0; p < NP; p++) begin
      do_lookup("R6 R7 miss discard", p, 12'hFFF, 4'(1 << p), 4'hF, 4'h9, 0, 0, '0);
      do_lookup("R8 miss no discard", p, 12'hFFF, ~4'(1 << p), 4'hF, 4'h6, 0, 0, '0);
    end
    // R11: single-bit VID differences
    for (int b = 0; b < 12; b++)
      do_lookup("R11 vid bit flip", b % NP, ent_vid(9) ^ 12'(1 << b), 4'h0, 4'hF, 4'h3, 0, 0, '0);
    // R3: overwrite an entry
    do_write(4, 1, ent_vid(4), 4'h6, 4'h2);
    do_lookup("R3 rewrite", 1, ent_vid(4), 4'hF, 4'hF, 4'h0, 0, 0, '0);
    // R5: duplicate ID, lowest index wins
    do_write(20, 1, ent_vid(5), 4'h9, 4'h8);
    for (int p = 0; p < NP; p++)
      do_lookup("R5 duplicate lowest", p, ent_vid(5), 4'hF, 4'hF, 4'h0, 0, 0, '0);
    // R4: free lower duplicate, higher one takes over, then free it too
    do_write(5, 0, '0, '0, '0);
    do_lookup("R4 R5 freed low dup", 0, ent_vid(5), 4'hF, 4'hF, 4'h0, 0, 0, '0);
    do_write(20, 0, '0, '0, '0);
    do_lookup("R4 freed miss", 0, ent_vid(5), 4'h0, 4'h0, 4'hC, 0, 0, '0);
    do_lookup("R4 freed miss discard", 3, ent_vid(5), 4'hF, 4'h0, 4'hC, 0, 0, '0);
    // R10: write in same cycle as lookup
    do_lookup("R10 same-cycle old", 2, 12'hABC, 4'h0, 4'hF, 4'h5, 1, 7, 12'hABC);
    do_lookup("R10 next-cycle new", 2, 12'hABC, 4'hF, 4'hF, 4'h5, 0, 0, '0);
    // R2: back-to-back requests each produce a strobe
    @(negedge clk); req = 1; vid = 12'hABC; port = 0;
    @(negedge clk); check("R2 b2b first", {31'd0, o_valid}, 32'd1);
    @(negedge clk); req = 0; check("R2 b2b second", {31'd0, o_valid}, 32'd1);
    @(negedge clk); check("R2 valid drops", {31'd0, o_valid}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule